// File: doc/BRIEF.md
# Timer counter with match and capture

A 32-bit time base for a chip subsystem. A prescaler divides an increment source, either the block clock (timer mode) or synchronized rising edges of the `count_in` pin (counter mode), and the main counter advances by one each time the prescaler wraps at its programmed limit. Four compare channels watch the counter. When one matches, it can set a sticky status flag, send the counter back to zero, stop it, and drive its own output pin low, high, toggle it or leave it alone. Four capture channels synchronize an input pin, look for a selected transition and copy the counter into a capture register.

Software configures the block through a single-cycle write port and a combinational read port. Run control is a four-state machine. ST_IDLE means not counting. ST_RUN means counting. ST_HOLD_IDLE and ST_HOLD_RUN both mean the counter and prescaler are forced to zero, with the enable bit remembered as clear or set. A write to the control register moves any state to the one given by its enable and hold bits. In ST_RUN, a match on a channel with the stop action moves the machine to ST_IDLE, and that move wins over a control write in the same cycle.

Top module: `tmr_core`

## Requirements
- R1: After reset, COUNT, PCNT and ISTAT read 0, CTRL reads 0 (state ST_IDLE), all `match_out` pins are 0 and `irq` is 0.
- R2: In timer mode (CTRL bit 2 = 0, bit 0 = 1), PCNT counts 0..P, where P is the PLIM value. COUNT advances by one on each wrap. After n clocks from the enable write, COUNT = n div (P+1) and PCNT = n mod (P+1).
- R3: While CTRL bit 1 (hold) is set, COUNT and PCNT stay at zero whatever the enable bit is. Counting resumes from zero when hold is cleared.
- R4: In counter mode (CTRL bit 2 = 1), each rising edge of `count_in` is one prescaler event after a two-flop synchronizer. COUNT advances once per P+1 edges and does not move without edges.
- R5: If MCTL bit 2i (reset action) is set, a tick taken while COUNT equals MATCHi makes the next value 0, so the counter cycles through 0..MATCHi.
- R6: If MCTL bit 2i+1 (stop action) is set, a tick taken while COUNT equals MATCHi leaves COUNT at that value and clears the enable bit (CTRL bit 0 reads 0).
- R7: OCTL bits [2i+1:2i] select the action of pin i at its match: 00 none, 01 drive low, 10 drive high, 11 toggle. The action is applied at the same edge as the counter's response. Other pins are untouched.
- R8: CCTL bits [2i+1:2i] select capture edges for channel i: 00 off, 01 rising, 10 falling, 11 both. On a selected edge, CAPi loads COUNT. Unselected edges change neither CAPi nor its flag.
- R9: ISTAT bit i (i<4) flags a match on channel i and bit 4+i flags a capture on channel i. Bits stay set until a 1 is written to them. Writing 0 leaves a bit as it is.
- R10: `irq` is high exactly when some ISTAT bit is set whose IEN bit (same position) is also set.
- R11: Register addresses: 0 CTRL, 1 PLIM, 2 COUNT, 3 PCNT, 4 ISTAT, 5 IEN, 6 MCTL, 7 OCTL, 8 CCTL, 16+i MATCHi, 24+i CAPi. COUNT, PCNT and CAPi are read-only and writes to them are ignored. `rdata` follows `addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, sampled at the rising clock edge |
| addr | input | 5 | Register address for both read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| count_in | input | 1 | External increment source for counter mode |
| cap_in | input | 4 | Capture trigger inputs, one per channel |
| match_out | output | 4 | Match-driven output pins, one per channel |
| irq | output | 1 | Interrupt request, OR of enabled status bits |

## Verification
A register write takes effect at the rising edge that samples it. With limit P, COUNT then changes at every (P+1)th edge after that. Match effects (flag, pin action, reset or stop) appear at the edge after a tick taken while the counter holds the match value. A pin change becomes a prescaler event or a capture at the third edge after it, because of the synchronizer. The bench drives on the falling edge and samples just after it, so every register stage is counted. The tests whose timing is exact (prescaler table, reset period, stop point) wait exact cycle counts. Capture and counter-mode tests freeze the counter or wait past the synchronizer latency before reading.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int unsigned ADDR_W = 5;

    localparam logic [ADDR_W-1:0] ADR_CTRL  = 5'd0;
    localparam logic [ADDR_W-1:0] ADR_PLIM  = 5'd1;
    localparam logic [ADDR_W-1:0] ADR_COUNT = 5'd2;
    localparam logic [ADDR_W-1:0] ADR_PCNT  = 5'd3;
    localparam logic [ADDR_W-1:0] ADR_ISTAT = 5'd4;
    localparam logic [ADDR_W-1:0] ADR_IEN   = 5'd5;
    localparam logic [ADDR_W-1:0] ADR_MCTL  = 5'd6;
    localparam logic [ADDR_W-1:0] ADR_OCTL  = 5'd7;
    localparam logic [ADDR_W-1:0] ADR_CCTL  = 5'd8;
    localparam logic [ADDR_W-1:0] ADR_MATCH = 5'd16;
    localparam logic [ADDR_W-1:0] ADR_CAP   = 5'd24;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } pin_act_e;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'b00,
        ST_RUN       = 2'b01,
        ST_HOLD_IDLE = 2'b10,
        ST_HOLD_RUN  = 2'b11
    } run_state_e;
endpackage

// File: rtl/tmr_ctrl_fsm.sv
module tmr_ctrl_fsm
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic wr_en_bit,
    input  logic wr_hold_bit,
    input  logic stop_hit,
    output logic run,
    output logic hold,
    output logic en_bit,
    output logic hold_bit
);
    run_state_e state_q, state_d;

    function automatic run_state_e decode(input logic en, input logic hd);
        if (hd) return en ? ST_HOLD_RUN : ST_HOLD_IDLE;
        else    return en ? ST_RUN : ST_IDLE;
    endfunction

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (stop_hit)     state_d = ST_IDLE;
                else if (ctrl_wr) state_d = decode(wr_en_bit, wr_hold_bit);
            end
            ST_IDLE, ST_HOLD_IDLE, ST_HOLD_RUN: begin
                if (ctrl_wr) state_d = decode(wr_en_bit, wr_hold_bit);
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:      begin run = 1'b0; hold = 1'b0; en_bit = 1'b0; hold_bit = 1'b0; end
            ST_RUN:       begin run = 1'b1; hold = 1'b0; en_bit = 1'b1; hold_bit = 1'b0; end
            ST_HOLD_IDLE: begin run = 1'b0; hold = 1'b1; en_bit = 1'b0; hold_bit = 1'b1; end
            ST_HOLD_RUN:  begin run = 1'b0; hold = 1'b1; en_bit = 1'b1; hold_bit = 1'b1; end
        endcase
    end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int unsigned CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          hold,
    input  logic          ext_mode,
    input  logic          ext_in,
    input  logic [CW-1:0] plim,
    input  logic          reset_hit,
    input  logic          stop_hit,
    output logic [CW-1:0] count,
    output logic [CW-1:0] pcnt,
    output logic          tick
);
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    logic ext_s1_q, ext_s2_q, ext_prev_q;
    logic inc_evt, wrap;

    assign inc_evt = ext_mode ? (ext_s2_q & ~ext_prev_q) : 1'b1;
    assign wrap    = (pcnt >= plim);
    assign tick    = run & inc_evt & wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_s1_q   <= 1'b0;
            ext_s2_q   <= 1'b0;
            ext_prev_q <= 1'b0;
            pcnt       <= '0;
            count      <= '0;
        end else begin
            ext_s1_q   <= ext_in;
            ext_s2_q   <= ext_s1_q;
            ext_prev_q <= ext_s2_q;
            if (hold) begin
                pcnt  <= '0;
                count <= '0;
            end else begin
                if (run && inc_evt) pcnt <= wrap ? '0 : pcnt + ONE;
                if (tick && !stop_hit) count <= reset_hit ? '0 : count + ONE;
            end
        end
    end
endmodule

// File: rtl/tmr_match.sv
module tmr_match
    import tmr_pkg::*;
#(
    parameter int unsigned CW = 32,
    parameter int unsigned NM = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic [CW-1:0]          count,
    input  logic [NM-1:0][CW-1:0]  match_val,
    input  logic [2*NM-1:0]        act_sel,
    input  logic [NM-1:0]          rst_sel,
    input  logic [NM-1:0]          stop_sel,
    output logic [NM-1:0]          hit,
    output logic [NM-1:0]          pin,
    output logic                   reset_hit,
    output logic                   stop_hit
);
    assign reset_hit = |(hit & rst_sel);
    assign stop_hit  = |(hit & stop_sel);

    for (genvar i = 0; i < NM; i++) begin : g_ch
        pin_act_e act;
        assign act    = pin_act_e'(act_sel[2*i +: 2]);
        assign hit[i] = tick && (count == match_val[i]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pin[i] <= 1'b0;
            end else if (hit[i]) begin
                unique case (act)
                    ACT_NONE:   ;
                    ACT_LOW:    pin[i] <= 1'b0;
                    ACT_HIGH:   pin[i] <= 1'b1;
                    ACT_TOGGLE: pin[i] <= ~pin[i];
                endcase
            end
        end
    end
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
    parameter int unsigned CW = 32,
    parameter int unsigned NC = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NC-1:0]          cap_in,
    input  logic [2*NC-1:0]        edge_sel,
    input  logic [CW-1:0]          count,
    output logic [NC-1:0][CW-1:0]  cap_val,
    output logic [NC-1:0]          cap_evt
);
    logic [NC-1:0] s1_q, s2_q, prev_q, rise, fall;

    assign rise = s2_q & ~prev_q;
    assign fall = ~s2_q & prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q   <= '0;
            s2_q   <= '0;
            prev_q <= '0;
        end else begin
            s1_q   <= cap_in;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    for (genvar i = 0; i < NC; i++) begin : g_ch
        assign cap_evt[i] = (edge_sel[2*i] & rise[i]) | (edge_sel[2*i+1] & fall[i]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cap_val[i] <= '0;
            else if (cap_evt[i]) cap_val[i] <= count;
        end
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int unsigned CW = 32,
    parameter int unsigned NM = 4,
    parameter int unsigned NC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CW-1:0]     wdata,
    output logic [CW-1:0]     rdata,
    input  logic              count_in,
    input  logic [NC-1:0]     cap_in,
    output logic [NM-1:0]     match_out,
    output logic              irq
);
    localparam int unsigned NS = NM + NC;

    logic                  ext_mode_q;
    logic [CW-1:0]         plim_q;
    logic [NS-1:0]         istat_q, istat_d, istat_clr, ien_q;
    logic [2*NM-1:0]       mctl_q, octl_q;
    logic [2*NC-1:0]       cctl_q;
    logic [NM-1:0][CW-1:0] match_q;
    logic [NC-1:0][CW-1:0] cap_w;
    logic [NC-1:0]         cap_evt_w;
    logic [NM-1:0]         hit_w, rst_sel_w, stop_sel_w;
    logic [CW-1:0]         count_w, pcnt_w;
    logic                  tick_w, run_w, hold_w, en_bit_w, hold_bit_w;
    logic                  reset_hit_w, stop_hit_w, ctrl_wr;

    assign ctrl_wr = wr_en && (addr == ADR_CTRL);

    tmr_ctrl_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
        .wr_en_bit(wdata[0]), .wr_hold_bit(wdata[1]), .stop_hit(stop_hit_w),
        .run(run_w), .hold(hold_w), .en_bit(en_bit_w), .hold_bit(hold_bit_w)
    );

    tmr_count #(.CW(CW)) u_count (
        .clk(clk), .rst_n(rst_n), .run(run_w), .hold(hold_w),
        .ext_mode(ext_mode_q), .ext_in(count_in), .plim(plim_q),
        .reset_hit(reset_hit_w), .stop_hit(stop_hit_w),
        .count(count_w), .pcnt(pcnt_w), .tick(tick_w)
    );

    for (genvar i = 0; i < NM; i++) begin : g_msel
        assign rst_sel_w[i]  = mctl_q[2*i];
        assign stop_sel_w[i] = mctl_q[2*i+1];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                match_q[i] <= '0;
            else if (wr_en && (addr == ADR_MATCH + ADDR_W'(i)))
                match_q[i] <= wdata;
        end
    end

    tmr_match #(.CW(CW), .NM(NM)) u_match (
        .clk(clk), .rst_n(rst_n), .tick(tick_w), .count(count_w),
        .match_val(match_q), .act_sel(octl_q), .rst_sel(rst_sel_w),
        .stop_sel(stop_sel_w), .hit(hit_w), .pin(match_out),
        .reset_hit(reset_hit_w), .stop_hit(stop_hit_w)
    );

    tmr_capture #(.CW(CW), .NC(NC)) u_cap (
        .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .edge_sel(cctl_q),
        .count(count_w), .cap_val(cap_w), .cap_evt(cap_evt_w)
    );

    assign istat_clr = (wr_en && (addr == ADR_ISTAT)) ? wdata[NS-1:0] : '0;
    assign istat_d   = (istat_q & ~istat_clr) | {cap_evt_w, hit_w};
    assign irq       = |(istat_q & ien_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_mode_q <= 1'b0;
            plim_q     <= '0;
            istat_q    <= '0;
            ien_q      <= '0;
            mctl_q     <= '0;
            octl_q     <= '0;
            cctl_q     <= '0;
        end else begin
            istat_q <= istat_d;
            if (wr_en) begin
                case (addr)
                    ADR_CTRL: ext_mode_q <= wdata[2];
                    ADR_PLIM: plim_q     <= wdata;
                    ADR_IEN:  ien_q      <= wdata[NS-1:0];
                    ADR_MCTL: mctl_q     <= wdata[2*NM-1:0];
                    ADR_OCTL: octl_q     <= wdata[2*NM-1:0];
                    ADR_CCTL: cctl_q     <= wdata[2*NC-1:0];
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADR_CTRL: begin
                rdata[0] = en_bit_w;
                rdata[1] = hold_bit_w;
                rdata[2] = ext_mode_q;
            end
            ADR_PLIM:  rdata = plim_q;
            ADR_COUNT: rdata = count_w;
            ADR_PCNT:  rdata = pcnt_w;
            ADR_ISTAT: rdata[NS-1:0]   = istat_q;
            ADR_IEN:   rdata[NS-1:0]   = ien_q;
            ADR_MCTL:  rdata[2*NM-1:0] = mctl_q;
            ADR_OCTL:  rdata[2*NM-1:0] = octl_q;
            ADR_CCTL:  rdata[2*NC-1:0] = cctl_q;
            default: begin
                for (int i = 0; i < NM; i++)
                    if (addr == ADR_MATCH + ADDR_W'(i)) rdata = match_q[i];
                for (int i = 0; i < NC; i++)
                    if (addr == ADR_CAP + ADDR_W'(i)) rdata = cap_w[i];
            end
        endcase
    end
endmodule

// File: rtl/tmr_core_chk.sv
module tmr_core_chk #(
    parameter int unsigned CW = 32,
    parameter int unsigned NM = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] count,
    input logic [CW-1:0] pcnt,
    input logic          tick,
    input logic          hold,
    input logic          run,
    input logic          stop_hit,
    input logic [NM-1:0] hit,
    input logic [NM-1:0] match_out
);
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    // R3
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (count == '0 && pcnt == '0));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> (count == $past(count) + ONE || count == '0));

    // R2
    count_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> ($past(tick) || $past(hold)));

    // R6
    stop_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_hit |=> !run);

    // R7
    pin_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_out != $past(match_out)) |-> ($past(hit) != '0));
endmodule

bind tmr_core tmr_core_chk #(.CW(CW), .NM(NM)) u_chk (
    .clk(clk), .rst_n(rst_n), .count(count_w), .pcnt(pcnt_w),
    .tick(tick_w), .hold(hold_w), .run(run_w), .stop_hit(stop_hit_w),
    .hit(hit_w), .match_out(match_out)
);

// File: tb/sim_tmr_core.sv
module sim_tmr_core;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // {limit, cycles, expected COUNT, expected PCNT}
    localparam logic [31:0] VEC [NVEC][4] = '{
        '{32'd0, 32'd5,  32'd5, 32'd0},
        '{32'd2, 32'd7,  32'd2, 32'd1},
        '{32'd1, 32'd9,  32'd4, 32'd1},
        '{32'd3, 32'd12, 32'd3, 32'd0},
        '{32'd4, 32'd4,  32'd0, 32'd4},
        '{32'd6, 32'd20, 32'd2, 32'd6}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        count_in = 1'b0;
    logic [3:0]  cap_in = '0;
    logic [3:0]  match_out;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] v;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_core u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .count_in(count_in), .cap_in(cap_in),
        .match_out(match_out), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] val);
        addr = a;
        #1 val = rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        // R1 reset state
        rd(5'd2, v); chk("R1 COUNT", v, 0);
        rd(5'd3, v); chk("R1 PCNT", v, 0);
        rd(5'd4, v); chk("R1 ISTAT", v, 0);
        rd(5'd0, v); chk("R1 CTRL", v, 0);
        chk("R1 pins", {28'd0, match_out}, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        for (int i = 0; i < 4; i++) wr(5'd16 + 5'(i), 32'hFFFF_FFFF);
        wr(5'd4, 32'hFF);

        // R2 prescaler table
        for (int k = 0; k < NVEC; k++) begin
            wr(5'd0, 32'd2);
            wr(5'd1, VEC[k][0]);
            wr(5'd0, 32'd1);
            wait_cyc(int'(VEC[k][1]));
            rd(5'd2, v); chk($sformatf("R2 COUNT vec%0d", k), v, VEC[k][2]);
            rd(5'd3, v); chk($sformatf("R11 R2 PCNT vec%0d", k), v, VEC[k][3]);
        end

        // R4 counter mode, limit 1, six edges
        wr(5'd0, 32'd6);
        wr(5'd1, 32'd1);
        wr(5'd0, 32'd5);
        for (int p = 0; p < 6; p++) begin
            count_in = 1'b1; wait_cyc(2);
            count_in = 1'b0; wait_cyc(2);
        end
        wait_cyc(4);
        rd(5'd2, v); chk("R4 COUNT after edges", v, 3);
        wait_cyc(10);
        rd(5'd2, v); chk("R4 COUNT without edges", v, 3);

        // R5 reset action with toggle on channel 0
        wr(5'd0, 32'd2);
        wr(5'd1, 32'd0);
        wr(5'd16, 32'd6);
        wr(5'd6, 32'h1);
        wr(5'd7, 32'h3);
        wr(5'd4, 32'hFF);
        wr(5'd0, 32'd1);
        wait_cyc(6);
        rd(5'd2, v); chk("R5 COUNT at match", v, 6);
        chk("R7 pin0 before", {31'd0, match_out[0]}, 0);
        wait_cyc(1);
        rd(5'd2, v); chk("R5 COUNT wrapped", v, 0);
        chk("R7 toggle pin0 high", {31'd0, match_out[0]}, 1);
        rd(5'd4, v); chk("R9 ISTAT match0", v, 32'h1);
        wait_cyc(7);
        rd(5'd2, v); chk("R5 COUNT second wrap", v, 0);
        chk("R7 toggle pin0 low", {31'd0, match_out[0]}, 0);

        // R9/R10 sticky flag and interrupt
        wr(5'd0, 32'd0);
        wr(5'd5, 32'h1);
        #1 chk("R10 irq enabled flag", {31'd0, irq}, 1);
        wr(5'd4, 32'h2);
        rd(5'd4, v); chk("R9 write zero keeps bit", v, 32'h1);
        wr(5'd4, 32'h1);
        rd(5'd4, v); chk("R9 write one clears", v, 0);
        chk("R10 irq after clear", {31'd0, irq}, 0);

        // R6 stop action with drive-high on channel 1
        wr(5'd0, 32'd2);
        wr(5'd16, 32'hFFFF_FFFF);
        wr(5'd17, 32'd4);
        wr(5'd6, 32'h8);
        wr(5'd7, 32'h8);
        wr(5'd4, 32'hFF);
        wr(5'd0, 32'd1);
        wait_cyc(8);
        rd(5'd2, v); chk("R6 COUNT held", v, 4);
        rd(5'd0, v); chk("R6 enable cleared", v, 0);
        chk("R7 high pin1", {31'd0, match_out[1]}, 1);
        rd(5'd4, v); chk("R9 ISTAT match1", v, 32'h2);
        chk("R10 masked flag", {31'd0, irq}, 0);
        wr(5'd5, 32'h2);
        #1 chk("R10 irq flag1 enabled", {31'd0, irq}, 1);
        wr(5'd5, 32'h0);

        // R7 toggle then drive-low on channel 2
        wr(5'd0, 32'd2);
        wr(5'd17, 32'hFFFF_FFFF);
        wr(5'd18, 32'd3);
        wr(5'd6, 32'h20);
        wr(5'd7, 32'h30);
        wr(5'd0, 32'd1);
        wait_cyc(6);
        rd(5'd2, v); chk("R6 COUNT stop ch2", v, 3);
        chk("R7 toggle pin2", {31'd0, match_out[2]}, 1);
        wr(5'd0, 32'd2);
        wr(5'd7, 32'h10);
        wr(5'd0, 32'd1);
        wait_cyc(6);
        chk("R7 low pin2", {31'd0, match_out[2]}, 0);
        chk("R7 pin1 untouched", {31'd0, match_out[1]}, 1);

        // R7 no action on channel 3
        wr(5'd0, 32'd2);
        wr(5'd18, 32'hFFFF_FFFF);
        wr(5'd19, 32'd2);
        wr(5'd6, 32'h80);
        wr(5'd7, 32'h0);
        wr(5'd4, 32'hFF);
        wr(5'd0, 32'd1);
        wait_cyc(5);
        rd(5'd2, v); chk("R6 COUNT stop ch3", v, 2);
        chk("R7 none pin3", {31'd0, match_out[3]}, 0);
        rd(5'd4, v); chk("R9 ISTAT match3", v, 32'h8);

        // R8 capture edges: ch0 rise, ch1 fall, ch2 both, ch3 off
        wr(5'd8, 32'h39);
        wr(5'd4, 32'hFF);
        cap_in = 4'hF;
        wait_cyc(5);
        rd(5'd24, v); chk("R8 CAP0 rise", v, 2);
        rd(5'd25, v); chk("R8 CAP1 rise ignored", v, 0);
        rd(5'd26, v); chk("R8 CAP2 rise", v, 2);
        rd(5'd27, v); chk("R8 CAP3 off", v, 0);
        rd(5'd4, v);  chk("R8 R9 capture flags rise", v, 32'h50);
        wr(5'd0, 32'd2);
        wr(5'd19, 32'd7);
        wr(5'd0, 32'd1);
        wait_cyc(10);
        wr(5'd4, 32'hFF);
        wr(5'd2, 32'h55);
        rd(5'd2, v); chk("R11 COUNT write ignored", v, 7);
        cap_in = 4'h0;
        wait_cyc(5);
        rd(5'd24, v); chk("R8 CAP0 fall ignored", v, 2);
        rd(5'd25, v); chk("R8 CAP1 fall", v, 7);
        rd(5'd26, v); chk("R8 CAP2 fall", v, 7);
        rd(5'd27, v); chk("R8 CAP3 off fall", v, 0);
        rd(5'd4, v);  chk("R8 R9 capture flags fall", v, 32'h60);

        // R3 hold with enable set, then release
        wr(5'd1, 32'd3);
        wr(5'd0, 32'd3);
        wait_cyc(5);
        rd(5'd2, v); chk("R3 COUNT held", v, 0);
        rd(5'd3, v); chk("R3 PCNT held", v, 0);
        wr(5'd0, 32'd1);
        wait_cyc(2);
        rd(5'd2, v); chk("R3 COUNT after release", v, 0);
        rd(5'd3, v); chk("R3 PCNT after release", v, 2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule